// File: doc/BRIEF.md
# Window/Timeout Watchdog Supervisor

This block supervises a host processor. Software must strobe a clear once per period. Each strobe marks a write of the watchdog register over the serial bus. A configuration bit makes the watchdog either a window watchdog or a plain timeout watchdog. In window mode, a clear that comes in the first half of the period (the closed window) is itself a fault. In both modes, a period that runs out with no valid clear is a fault.

What happens on a fault depends on the operating mode. In normal mode the host reset is pulled low for a fixed number of ticks and then released. In safe mode the reset line is left alone, and an active-low watchdog flag is latched low until software next writes the watchdog register. A supply-good input overrides everything: while the supply is out of range, reset is held low.

Time is counted in periodic millisecond ticks. Period and type changes are latched only when the counter restarts, so a running period never changes its length or window partway through.

Top module: `wdt_supervisor`

## Requirements
- R1: `cfg_timeout_mode` = 0 selects window mode and 1 selects timeout mode. The selection in force is loaded only when the period counter restarts.
- R2: `cfg_period_sel` values 0, 1, 2 and 3 select periods of 10, 50, 150 and 350 ticks. With no valid clear, the fault is taken on the edge that consumes the period's last tick, counted from the restart.
- R3: In window mode, a clear with at least half the period elapsed is accepted. It restarts the period, and both outputs stay high.
- R4: In window mode, a clear with fewer than half the period's ticks elapsed is a fault.
- R5: In normal mode (`cfg_safe_mode` = 0), a fault drives `host_rst_n` low from the next edge. The output stays low for RST_TICKS ticks (default 20) and goes high on the edge that consumes the last of them. The period then starts again from zero.
- R6: In safe mode, a fault leaves `host_rst_n` high and drives `wd_flag_n` low. The flag stays low until the next clear strobe. That strobe releases the flag and restarts the period whatever the window position.
- R7: While `supply_ok` is 0, `host_rst_n` is low from the next edge on. It returns high one edge after `supply_ok` returns, with the period counter restarted.
- R8: In timeout mode a clear is accepted at any count, including zero.
- R9: A change to type or period while a period runs does not affect that period. For example, switching to timeout mode mid-period still faults an early clear.
- R10: While `rst_n` is low, `host_rst_n` is low and `wd_flag_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power reset, released synchronously inside |
| tick_ms | input | 1 | One-cycle millisecond tick |
| cfg_timeout_mode | input | 1 | 0 window, 1 timeout |
| cfg_period_sel | input | 2 | Period select: 10/50/150/350 ticks |
| cfg_safe_mode | input | 1 | 0 normal (faults reset host), 1 safe (faults set flag) |
| clear_stb | input | 1 | One-cycle watchdog register write strobe |
| supply_ok | input | 1 | Supply in range |
| host_rst_n | output | 1 | Active-low host reset |
| wd_flag_n | output | 1 | Active-low latched watchdog fault flag |

## Verification
The counter and the window boundary live inside the block, so faults there show up only at the reset and flag pins. A count that is one off moves the fault edge by one tick. A misplaced window boundary turns an accepted clear into a reset, or the other way round, on the very next edge. Each check therefore lands on the exact edge where a fault should or should not fire. These edges are the half-period boundary, the last period tick, the last reset tick, and the edge after a supply change. A cycle model runs alongside randomized clears, ticks, configuration changes and supply drops, and compares both pins every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,   // supply out of range or power reset
    ST_RSTW = 2'd1,   // timed host reset after a fault
    ST_RUN  = 2'd2    // host running, watchdog active
  } sup_state_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/wdt_period_ctr.sv
module wdt_period_ctr #(
  parameter int unsigned PER0 = 10,
  parameter int unsigned PER1 = 50,
  parameter int unsigned PER2 = 150,
  parameter int unsigned PER3 = 350
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic [1:0] sel_in,
  input  logic       timeout_in,
  output logic       expire,
  output logic       open_win
);
  localparam int unsigned CW = $clog2(PER3 + 1);
  localparam logic [CW-1:0] LIM0 = CW'(PER0);
  localparam logic [CW-1:0] LIM1 = CW'(PER1);
  localparam logic [CW-1:0] LIM2 = CW'(PER2);
  localparam logic [CW-1:0] LIM3 = CW'(PER3);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic          to_q, to_d;
  logic [CW-1:0] lim_sel;

  always_comb begin
    case (sel_in)
      2'd0:    lim_sel = LIM0;
      2'd1:    lim_sel = LIM1;
      2'd2:    lim_sel = LIM2;
      default: lim_sel = LIM3;
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    to_d  = to_q;
    if (restart) begin
      cnt_d = '0;
      lim_d = lim_sel;
      to_d  = timeout_in;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= LIM0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      to_q  <= to_d;
    end
  end

  assign expire   = tick && (cnt_q == lim_q - 1'b1);
  assign open_win = to_q || (cnt_q >= (lim_q >> 1));
endmodule

// File: rtl/wdt_rst_timer.sv
module wdt_rst_timer #(
  parameter int unsigned RST_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic done
);
  localparam int unsigned RW = $clog2(RST_TICKS + 1);
  localparam logic [RW-1:0] LAST = RW'(RST_TICKS - 1);

  logic [RW-1:0] cnt_q, cnt_d;

  assign done = active && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!active || done) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor #(
  parameter int unsigned PER0      = 10,
  parameter int unsigned PER1      = 50,
  parameter int unsigned PER2      = 150,
  parameter int unsigned PER3      = 350,
  parameter int unsigned RST_TICKS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       cfg_timeout_mode,
  input  logic [1:0] cfg_period_sel,
  input  logic       cfg_safe_mode,
  input  logic       clear_stb,
  input  logic       supply_ok,
  output logic       host_rst_n,
  output logic       wd_flag_n
);
  import wdt_pkg::*;

  logic       srst_n;
  sup_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       win_open, per_expire, rst_done;
  logic       clr_ok, fault, restart, in_run;

  wdt_rst_sync u_sync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  assign in_run = (state_q == ST_RUN) && supply_ok;
  // a clear is good in the open window, in timeout mode, or to release the flag
  assign clr_ok  = in_run && clear_stb && (win_open || !flag_q);
  assign fault   = in_run && (clear_stb ? !clr_ok : per_expire);
  assign restart = !in_run || clr_ok || fault;

  wdt_period_ctr #(.PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)) u_ctr (
    .clk(clk), .rst_n(srst_n), .restart(restart), .tick(tick_ms),
    .sel_in(cfg_period_sel), .timeout_in(cfg_timeout_mode),
    .expire(per_expire), .open_win(win_open)
  );

  wdt_rst_timer #(.RST_TICKS(RST_TICKS)) u_rtmr (
    .clk(clk), .rst_n(srst_n), .active(state_q == ST_RSTW && supply_ok),
    .tick(tick_ms), .done(rst_done)
  );

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    if (!supply_ok) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_HOLD: state_d = ST_RUN;
        ST_RSTW: if (rst_done) state_d = ST_RUN;
        ST_RUN: begin
          if (clr_ok) flag_d = 1'b1;
          if (fault) begin
            if (cfg_safe_mode) flag_d  = 1'b0;
            else               state_d = ST_RSTW;
          end
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_HOLD;
      flag_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign host_rst_n = (state_q == ST_RUN);
  assign wd_flag_n  = flag_q;
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic clear_stb,
  input logic cfg_safe_mode,
  input logic supply_ok,
  input logic host_rst_n,
  input logic wd_flag_n,
  input logic win_open
);
  // R7
  a_r7_supply_low_resets: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !host_rst_n);

  // R4
  a_r4_closed_clear_faults: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst_n && supply_ok && clear_stb && !win_open && wd_flag_n && !cfg_safe_mode
    |=> !host_rst_n);

  // R6
  a_r6_safe_keeps_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
    host_rst_n && supply_ok && cfg_safe_mode |=> host_rst_n);

  // R6
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_flag_n && !clear_stb |=> !wd_flag_n);

  // R6
  a_r6_flag_release_by_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag_n) |-> $past(clear_stb));

  // R10
  always_comb begin
    if (!rst_n) begin
      a_r10_reset_state: assert (!host_rst_n || $isunknown(host_rst_n));
    end
  end
endmodule

bind wdt_supervisor wdt_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clear_stb(clear_stb), .cfg_safe_mode(cfg_safe_mode),
  .supply_ok(supply_ok), .host_rst_n(host_rst_n), .wd_flag_n(wd_flag_n),
  .win_open(win_open)
);

// File: tb/wdt_supervisor_bench.sv
module wdt_supervisor_bench;
  localparam int unsigned RSTT = 20;

  logic       clk = 1'b0;
  logic       rst_n, tick_ms, cfg_timeout_mode, cfg_safe_mode, clear_stb, supply_ok;
  logic [1:0] cfg_period_sel;
  logic       host_rst_n, wd_flag_n;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #4 clk = ~clk;   // 125 MHz

  wdt_supervisor u_wdt_supervisor (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .cfg_timeout_mode(cfg_timeout_mode),
    .cfg_period_sel(cfg_period_sel), .cfg_safe_mode(cfg_safe_mode),
    .clear_stb(clear_stb), .supply_ok(supply_ok),
    .host_rst_n(host_rst_n), .wd_flag_n(wd_flag_n)
  );

  function automatic int per_of(input logic [1:0] s);
    case (s)
      2'd0: return 10;
      2'd1: return 50;
      2'd2: return 150;
      default: return 350;
    endcase
  endfunction

  // reference model, written from the requirements
  int m_state;   // 0 hold, 1 reset wait, 2 run
  int m_cnt, m_rcnt, m_lim;
  bit m_to, m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_rcnt <= 0; m_lim <= 10; m_to <= 0; m_flag <= 1;
    end else if (!supply_ok) begin
      m_state <= 0; m_cnt <= 0; m_rcnt <= 0;
      m_lim <= per_of(cfg_period_sel); m_to <= cfg_timeout_mode;
    end else begin
      case (m_state)
        0: begin
          m_state <= 2; m_cnt <= 0;
          m_lim <= per_of(cfg_period_sel); m_to <= cfg_timeout_mode;
        end
        1: begin
          m_cnt <= 0; m_lim <= per_of(cfg_period_sel); m_to <= cfg_timeout_mode;
          if (tick_ms) begin
            if (m_rcnt == RSTT - 1) begin m_state <= 2; m_rcnt <= 0; end
            else m_rcnt <= m_rcnt + 1;
          end
        end
        default: begin
          bit flt;
          flt = 0;
          if (clear_stb) begin
            if (!m_flag || m_to || m_cnt >= m_lim / 2) begin
              m_flag <= 1; m_cnt <= 0;
              m_lim <= per_of(cfg_period_sel); m_to <= cfg_timeout_mode;
            end else flt = 1;
          end else if (tick_ms) begin
            if (m_cnt == m_lim - 1) flt = 1;
            else m_cnt <= m_cnt + 1;
          end
          if (flt) begin
            m_cnt <= 0; m_lim <= per_of(cfg_period_sel); m_to <= cfg_timeout_mode;
            if (cfg_safe_mode) m_flag <= 0;
            else begin m_state <= 1; m_rcnt <= 0; end
          end
        end
      endcase
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, mid high phase
  always begin
    @(posedge clk); #2;
    if (rst_n && !done) begin
      chk(host_rst_n, (m_state == 2), "R5/R7 model host_rst_n");
      chk(wd_flag_n, m_flag, "R6 model wd_flag_n");
    end
  end

  task automatic step(input logic t, input logic c);
    @(negedge clk);
    tick_ms = t; clear_stb = c;
    @(posedge clk); #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; tick_ms = 0; clear_stb = 0; supply_ok = 0;
    cfg_timeout_mode = 0; cfg_period_sel = 2'd0; cfg_safe_mode = 0;
    #20;
    chk(host_rst_n, 1'b0, "R10 reset host");
    chk(wd_flag_n, 1'b1, "R10 reset flag");
    @(negedge clk) rst_n = 1;
    repeat (4) step(0, 0);
    chk(host_rst_n, 1'b0, "R7 supply low after reset");
    supply_ok = 1;
    step(0, 0);
    chk(host_rst_n, 1'b1, "R7 release on supply good");

    // R4 early clear in window, then R5 reset length
    ticks(2); step(0, 1);
    chk(host_rst_n, 1'b0, "R4 early clear faults");
    ticks(RSTT - 1);
    chk(host_rst_n, 1'b0, "R5 still in reset");
    ticks(1);
    chk(host_rst_n, 1'b1, "R5 released after duration");

    // R3 clear at half period, R2 timeout on 10th tick
    ticks(5); step(0, 1);
    chk(host_rst_n, 1'b1, "R3 open window clear accepted");
    ticks(9);
    chk(host_rst_n, 1'b1, "R2 before last tick");
    ticks(1);
    chk(host_rst_n, 1'b0, "R2 timeout on last tick");
    ticks(RSTT);

    // R9 type change mid-period does not apply
    cfg_timeout_mode = 1;
    ticks(1); step(0, 1);
    chk(host_rst_n, 1'b0, "R9 window still active");
    ticks(RSTT);
    // R1/R8 timeout mode now latched
    ticks(1); step(0, 1);
    chk(host_rst_n, 1'b1, "R8 R1 early clear ok in timeout mode");
    step(0, 1);
    chk(host_rst_n, 1'b1, "R8 clear at count zero");

    // R6 safe mode
    cfg_safe_mode = 1; cfg_timeout_mode = 0;
    step(0, 1);            // latches window mode
    step(0, 1);            // early clear
    chk(wd_flag_n, 1'b0, "R6 flag low on fault");
    chk(host_rst_n, 1'b1, "R6 reset untouched");
    ticks(30);
    chk(wd_flag_n, 1'b0, "R6 flag sticky");
    step(0, 1);
    chk(wd_flag_n, 1'b1, "R6 flag released by clear");

    // R2 longest period
    cfg_safe_mode = 0; cfg_period_sel = 2'd3;
    ticks(5); step(0, 1);
    ticks(349);
    chk(host_rst_n, 1'b1, "R2 350 before last tick");
    ticks(1);
    chk(host_rst_n, 1'b0, "R2 350 timeout");
    ticks(RSTT);

    // R7 supply dropout
    supply_ok = 0;
    step(0, 0);
    chk(host_rst_n, 1'b0, "R7 supply drop");
    repeat (3) step(1, 0);
    chk(host_rst_n, 1'b0, "R7 held low");
    supply_ok = 1;
    step(0, 0);
    chk(host_rst_n, 1'b1, "R7 back in range");

    // constrained random phase
    void'($urandom(32'd4242));
    cfg_period_sel = 2'd0;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      tick_ms   = ($urandom % 4) == 0;
      clear_stb = ($urandom % 12) == 0;
      if (($urandom % 500) == 0) begin
        cfg_timeout_mode = $urandom % 2;
        cfg_period_sel   = ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd0;
        cfg_safe_mode    = $urandom % 2;
      end
      if (supply_ok && ($urandom % 4000) == 0) supply_ok = 0;
      else if (!supply_ok && ($urandom % 10) == 0) supply_ok = 1;
    end
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule